// File: doc/BRIEF.md
# Test-Access Switch State Controller

This block is the digital control core for an eight-switch subscriber line access device. A three-bit control code, written {A,B,C} with A as the most significant bit, passes through a transparent hold stage governed by a hold input. The effective code is decoded into four switch pairs: break, test-out, test-in and test-bridge. The result is registered into an eight-bit switch-enable vector.

Three conditions force every switch off. The first is a supply lockout input. The second is an active-low external all-off request. The third is a thermal monitor that compares a digital die-temperature code against a trip threshold and a lower release threshold. The thermal monitor also drives an open-drain style pull-low request for the shared shutdown flag.

Supply lockout presets the held code to the all-off code. As a result, after the supply recovers the switches stay off until the hold input is taken low. The external and thermal overrides mask the outputs but leave the held code untouched. When one of them clears, the switches return to the held state.

Top module: `tas_ctrl`

## Requirements
- R1: The switch vector places the break pair on bits 1:0, the test-out pair on bits 3:2, the test-in pair on bits 5:4 and the bridge pair on bits 7:6. Codes map to pairs as follows:
  - 000: break.
  - 001: test-in.
  - 010: test-out.
  - 011: break and test-in.
  - 100: break and test-out.
  - 101: test-in and test-out.
  - 110: none.
  - 111: test-in and bridge.
- R2: While the hold input is low and no override is active, the switch vector shows the decode of the present control code at the next rising clock edge.
- R3: While the hold input is high, changes on the control code have no effect on the switch vector.
- R4: While lockout is high, the switch vector is all zero from the next edge on, and the held code becomes 110.
- R5: If lockout clears while the hold input is high, the switches remain off until the hold input goes low.
- R6: If lockout clears while the hold input is low, the switch vector follows the control code from the next edge.
- R7: When the temperature code is at or above the trip threshold (default 125), the pull-low flag is set at the next edge. From the edge after that, every switch is off for as long as the flag stays set.
- R8: Once set, the flag stays set until the temperature code is at or below the release threshold (default 105). It then clears at the next edge, without any other action.
- R9: A low external all-off request forces the switch vector to zero at the next edge, whatever the hold input is.
- R10: External and thermal overrides do not alter the held code. When they clear with the hold input still high, the previously held switch state returns.
- R11: After reset the switch vector is zero, the flag is released, and the held code is 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_code_i | input | 3 | Control code {A,B,C} |
| hold_i | input | 1 | High: keep held code; low: transparent |
| uvlo_i | input | 1 | Supply lockout, active high |
| alloff_n_i | input | 1 | External all-off request, active low |
| temp_i | input | TEMP_W | Die temperature code in degrees |
| sw_en_o | output | 8 | Switch enables, four pairs |
| tsd_pull_o | output | 1 | High requests the shared flag be pulled low |

## Verification
The bench targets the lockout release with hold high. A design that reloads the code there, instead of presetting it, would close switches before the host takes the hold input low. It walks the temperature across the hysteresis band: at 124, at 125, back down to 110 and 106, and finally to 105. This exposes trip comparisons that are off by one and releases that happen too early. It also clears thermal and external overrides while hold is high, to catch a design that overwrote the held code and so returns to all-off or to a stale state. Randomized stimulus then mixes these conditions against a reference model.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int CODE_W      = 3;
  localparam int NUM_PAIRS   = 4;
  localparam int SW_PER_PAIR = 2;

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [NUM_PAIRS-1:0] pair_t;

  localparam int PAIR_BREAK  = 0;
  localparam int PAIR_TOUT   = 1;
  localparam int PAIR_TIN    = 2;
  localparam int PAIR_BRIDGE = 3;

  localparam code_t CODE_ALL_OFF = 3'b110;

  // Pair selection for each effective control code.
  function automatic pair_t pairs_for_code(input code_t c);
    pair_t p;
    p = '0;
    unique case (c)
      3'b000: p[PAIR_BREAK] = 1'b1;
      3'b001: p[PAIR_TIN] = 1'b1;
      3'b010: p[PAIR_TOUT] = 1'b1;
      3'b011: begin
        p[PAIR_BREAK] = 1'b1;
        p[PAIR_TIN]   = 1'b1;
      end
      3'b100: begin
        p[PAIR_BREAK] = 1'b1;
        p[PAIR_TOUT]  = 1'b1;
      end
      3'b101: begin
        p[PAIR_TIN]  = 1'b1;
        p[PAIR_TOUT] = 1'b1;
      end
      3'b110: p = '0;
      3'b111: begin
        p[PAIR_TIN]    = 1'b1;
        p[PAIR_BRIDGE] = 1'b1;
      end
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tas_code_latch.sv
module tas_code_latch
  import tas_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  code_t ctl_i,
  input  logic  hold_i,
  input  logic  lock_i,
  output code_t eff_o,
  output code_t held_o
);
  code_t held_q, held_d;
  logic  held_en;

  // Transparent path while open; otherwise the stored code.
  assign eff_o  = (!hold_i && !lock_i) ? ctl_i : held_q;
  assign held_o = held_q;

  always_comb begin
    held_en = lock_i || !hold_i;
    held_d  = held_q;
    if (lock_i) begin
      held_d = CODE_ALL_OFF;
    end else if (!hold_i) begin
      held_d = ctl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      held_q <= CODE_ALL_OFF;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end
endmodule

// File: rtl/tas_thermal_mon.sv
module tas_thermal_mon #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 125,
  parameter int REL_C  = 105
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic              hot_o
);
  localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_C);
  localparam logic [TEMP_W-1:0] REL_V  = TEMP_W'(REL_C);

  logic hot_q, hot_d;

  always_comb begin
    hot_d = hot_q;
    if (hot_q) begin
      if (temp_i <= REL_V) hot_d = 1'b0;
    end else begin
      if (temp_i >= TRIP_V) hot_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hot_q <= 1'b0;
    end else begin
      hot_q <= hot_d;
    end
  end

  assign hot_o = hot_q;
endmodule

// File: rtl/tas_switch_drive.sv
module tas_switch_drive
  import tas_pkg::*;
#(
  parameter int PAIRS    = NUM_PAIRS,
  parameter int PER_PAIR = SW_PER_PAIR,
  localparam int SW_W    = PAIRS * PER_PAIR
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [PAIRS-1:0] pairs_i,
  input  logic             force_off_i,
  output logic [SW_W-1:0]  sw_o
);
  logic [SW_W-1:0] sw_raw, sw_d, sw_q;

  // Expand each pair enable onto its member switches.
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar s = 0; s < PER_PAIR; s++) begin : g_member
      assign sw_raw[p*PER_PAIR + s] = pairs_i[p];
    end
  end

  always_comb begin
    sw_d = force_off_i ? '0 : sw_raw;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sw_q <= '0;
    end else begin
      sw_q <= sw_d;
    end
  end

  assign sw_o = sw_q;
endmodule

// File: rtl/tas_ctrl.sv
module tas_ctrl
  import tas_pkg::*;
#(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 125,
  parameter int REL_C  = 105,
  localparam int SW_W  = NUM_PAIRS * SW_PER_PAIR
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [2:0]        ctl_code_i,
  input  logic              hold_i,
  input  logic              uvlo_i,
  input  logic              alloff_n_i,
  input  logic [TEMP_W-1:0] temp_i,
  output logic [SW_W-1:0]   sw_en_o,
  output logic              tsd_pull_o
);
  logic  rst_sync_q1, rst_n_sync;
  code_t eff_code, held_code;
  pair_t pair_sel;
  logic  hot, force_off;

  // Reset synchronizer: asserts at once, releases on the clock.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_sync_q1 <= 1'b0;
      rst_n_sync  <= 1'b0;
    end else begin
      rst_sync_q1 <= 1'b1;
      rst_n_sync  <= rst_sync_q1;
    end
  end

  tas_code_latch i_latch (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_sync),
    .ctl_i   (ctl_code_i),
    .hold_i  (hold_i),
    .lock_i  (uvlo_i),
    .eff_o   (eff_code),
    .held_o  (held_code)
  );

  tas_thermal_mon #(
    .TEMP_W (TEMP_W),
    .TRIP_C (TRIP_C),
    .REL_C  (REL_C)
  ) i_thermal (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_sync),
    .temp_i  (temp_i),
    .hot_o   (hot)
  );

  assign pair_sel  = pairs_for_code(eff_code);
  assign force_off = uvlo_i || !alloff_n_i || hot;

  tas_switch_drive #(
    .PAIRS    (NUM_PAIRS),
    .PER_PAIR (SW_PER_PAIR)
  ) i_drive (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_sync),
    .pairs_i     (pair_sel),
    .force_off_i (force_off),
    .sw_o        (sw_en_o)
  );

  assign tsd_pull_o = hot;
endmodule

// File: rtl/tas_ctrl_chk.sv
module tas_ctrl_chk #(
  parameter int TEMP_W = 8,
  parameter int TRIP_C = 125,
  parameter int REL_C  = 105
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              hold_i,
  input logic              uvlo_i,
  input logic              alloff_n_i,
  input logic [TEMP_W-1:0] temp_i,
  input logic [7:0]        sw_en_o,
  input logic              tsd_pull_o,
  input logic [2:0]        held_i
);
  assert_uvlo_off_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    uvlo_i |=> (sw_en_o == 8'h00));
  assert_uvlo_preset_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    uvlo_i |=> (held_i == 3'b110));
  assert_hold_keeps_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (hold_i && !uvlo_i) |=> $stable(held_i));
  assert_ext_off_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !alloff_n_i |=> (sw_en_o == 8'h00));
  assert_trip_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (temp_i >= TEMP_W'(TRIP_C)) |=> tsd_pull_o);
  assert_hot_off_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    tsd_pull_o |=> (sw_en_o == 8'h00));
  assert_hyst_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (tsd_pull_o && temp_i > TEMP_W'(REL_C)) |=> tsd_pull_o);
  assert_no_early_trip_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!tsd_pull_o && temp_i < TEMP_W'(TRIP_C)) |=> !tsd_pull_o);
  assert_pairs_R1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sw_en_o[0] == sw_en_o[1]) && (sw_en_o[2] == sw_en_o[3]) &&
    (sw_en_o[4] == sw_en_o[5]) && (sw_en_o[6] == sw_en_o[7]));
endmodule

bind tas_ctrl tas_ctrl_chk #(
  .TEMP_W (TEMP_W),
  .TRIP_C (TRIP_C),
  .REL_C  (REL_C)
) i_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_sync),
  .hold_i     (hold_i),
  .uvlo_i     (uvlo_i),
  .alloff_n_i (alloff_n_i),
  .temp_i     (temp_i),
  .sw_en_o    (sw_en_o),
  .tsd_pull_o (tsd_pull_o),
  .held_i     (held_code)
);

// File: tb/test_tas_ctrl.sv
module test_tas_ctrl;
  localparam int TRIP = 125;
  localparam int REL  = 105;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ctl;
  logic       hold, uvlo, alloff_n;
  logic [7:0] temp;
  logic [7:0] sw;
  logic       pull;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [2:0] m_code;
  logic       m_hot;

  always #2.5 clk = ~clk;

  tas_ctrl i_tas_ctrl (
    .clk_i      (clk),
    .rst_n_i    (rst_n),
    .ctl_code_i (ctl),
    .hold_i     (hold),
    .uvlo_i     (uvlo),
    .alloff_n_i (alloff_n),
    .temp_i     (temp),
    .sw_en_o    (sw),
    .tsd_pull_o (pull)
  );

  function automatic logic [7:0] exp_sw(input logic [2:0] c);
    case (c)
      3'b000:  return 8'b0000_0011;
      3'b001:  return 8'b0011_0000;
      3'b010:  return 8'b0000_1100;
      3'b011:  return 8'b0011_0011;
      3'b100:  return 8'b0000_1111;
      3'b101:  return 8'b0011_1100;
      3'b111:  return 8'b1111_0000;
      default: return 8'b0000_0000;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic h, input logic u,
                      input logic an, input logic [7:0] t, input string tag);
    logic [2:0] eff;
    logic [7:0] e_sw;
    logic       frc, nhot;
    @(negedge clk);
    ctl = c; hold = h; uvlo = u; alloff_n = an; temp = t;
    eff  = (!h && !u) ? c : m_code;
    frc  = u || !an || m_hot;
    e_sw = frc ? 8'h00 : exp_sw(eff);
    nhot = m_hot ? !(t <= REL) : (t >= TRIP);
    if (u) m_code = 3'b110;
    else if (!h) m_code = c;
    m_hot = nhot;
    @(posedge clk);
    #1;
    check({tag, " switches"}, sw, e_sw);
    check({tag, " flag"}, {7'b0, pull}, {7'b0, nhot});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ctl = 3'b000; hold = 1'b1; uvlo = 1'b0; alloff_n = 1'b1; temp = 8'd25;
    m_code = 3'b110; m_hot = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset switches", sw, 8'h00);
    check("R11 reset flag", {7'b0, pull}, 8'h00);
    // R11: held code all-off, so hold high keeps switches off.
    step(3'b000, 1, 0, 1, 25, "R11");
    // R1 and R2: every code, transparent path.
    for (int c = 0; c < 8; c++) step(3'(c), 0, 0, 1, 25, "R1");
    step(3'b000, 0, 0, 1, 25, "R2");
    step(3'b101, 0, 0, 1, 25, "R2");
    step(3'b000, 0, 0, 1, 25, "R2");
    // R3: hold high ignores code changes.
    step(3'b101, 1, 0, 1, 25, "R3");
    step(3'b111, 1, 0, 1, 25, "R3");
    // R4, R5: lockout, release with hold high.
    step(3'b000, 1, 1, 1, 25, "R4");
    step(3'b000, 1, 0, 1, 25, "R5");
    step(3'b010, 1, 0, 1, 25, "R5");
    step(3'b000, 0, 0, 1, 25, "R5");
    // R4, R6: lockout, release with hold low.
    step(3'b011, 0, 1, 1, 25, "R4");
    step(3'b011, 0, 0, 1, 25, "R6");
    // R7, R8, R10: thermal trip and hysteresis with hold high.
    step(3'b000, 1, 0, 1, 124, "R7");
    step(3'b000, 1, 0, 1, 125, "R7");
    step(3'b000, 1, 0, 1, 125, "R7");
    step(3'b000, 1, 0, 1, 110, "R8");
    step(3'b000, 1, 0, 1, 106, "R8");
    step(3'b000, 1, 0, 1, 105, "R8");
    step(3'b000, 1, 0, 1, 25, "R10");
    // R9, R10: external all-off.
    step(3'b101, 1, 0, 0, 25, "R9");
    step(3'b101, 1, 0, 1, 25, "R10");
    step(3'b100, 0, 0, 0, 25, "R9");
    step(3'b100, 0, 0, 1, 25, "R9");
    // Randomized mix.
    for (int i = 0; i < 3000; i++) begin
      step(3'($urandom % 8), ($urandom % 4) == 0, ($urandom % 40) == 0,
           ($urandom % 20) != 0, 8'(90 + $urandom % 50), "R1 random");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule